// File: doc/BRIEF.md
# Card Data Path Sequencer with Timeouts

This block sequences a single block-oriented data transfer between a host and a memory card bus. A start strobe in the idle state loads a remaining-byte counter from the programmed length. The sequencer then enters a receive-wait or a send-wait state, depending on the direction bit. Each word strobe marks one 32-bit word moved, and it takes four bytes off the count, stopping at zero. Once the count is exhausted, a send transfer waits for the card to release busy. A receive transfer either ends at that point or, when an acknowledgment is requested, waits for the card's acknowledgment.

Two down-counting watchdogs guard the waiting states. The data timer runs in the receive-wait and busy states, and the acknowledgment timer runs in the acknowledgment-wait state. Both timers advance only on a one-cycle card-clock enable pulse. Each timer is reloaded from its programmed value whenever the sequencer is outside the states it guards, so every entry into a guarded state starts a fresh count. The block reports each outcome with a one-cycle pulse: data end, data timeout or acknowledgment timeout. An error input aborts the transfer without raising any of these pulses. Bit shifting, CRC, FIFO and DMA are handled elsewhere.

Top module: `card_dpath_seq`

## Requirements
- R1: After a synchronous reset, whether asserted from idle or in the middle of a transfer, the state is Idle (code 0), the count is 0 and all three flags are 0. State codes: Idle 0, WaitSend 1, Send 2, Busy 3, WaitRecv 4, Recv 5, WaitAck 6.
- R2: In Idle, a start strobe loads the count from `cfg_len`. On the next cycle the state is WaitRecv (4) when `dir_rx`=1 and WaitSend (1) when `dir_rx`=0.
- R3: In Send or Recv, each `word_stb` lowers the count by 4, and a count below 4 goes to 0. Outside those states the count holds. A start strobe outside Idle changes neither the state nor the count.
- R4: WaitSend moves to Send on a `ck_en` pulse. WaitRecv moves to Recv on a `ck_en` pulse with `rx_begin`=1.
- R5: The state moves on the cycle after the count is first seen at 0. Send moves to Busy. Recv moves to WaitAck when `ack_req`=1; otherwise it moves to Idle and pulses `data_end`.
- R6: In Busy, a `ck_en` pulse with `card_busy`=0 moves the state to Idle and pulses `data_end`. In WaitAck, a `ck_en` pulse with `ack_in`=1 does the same.
- R7: The data timer holds `cfg_dtime` while the state is neither WaitRecv nor Busy. In those two states it counts `ck_en` pulses. On the N-th pulse (N=`cfg_dtime`, with 0 treated as 1) the state moves to Idle and `data_tmo` pulses. Every entry into WaitRecv or Busy starts from the full value.
- R8: The acknowledgment timer counts `ck_en` pulses in WaitAck in the same way, using `cfg_atime`. When it expires, the state moves to Idle and `ack_tmo` pulses.
- R9: If the completing condition and timer expiry fall on the same `ck_en` pulse, the completing condition wins.
- R10: `err_in` outside Idle moves the state to Idle on the next cycle with no flag raised. In Idle, `err_in` has no effect.
- R11: Each flag is high for exactly one cycle. At most one flag is high at a time, and a flag is high only on the first cycle back in Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ck_en | input | 1 | One-cycle card-clock enable pulse |
| cfg_len | input | LEN_W | Transfer length in bytes |
| cfg_dtime | input | TMR_W | Data timeout, in card clock pulses |
| cfg_atime | input | TMR_W | Acknowledgment timeout, in card clock pulses |
| start | input | 1 | Transfer start strobe |
| dir_rx | input | 1 | 1 = receive, 0 = send |
| ack_req | input | 1 | Receive ends with an acknowledgment wait |
| word_stb | input | 1 | One 32-bit word transferred |
| rx_begin | input | 1 | Card start of data seen |
| card_busy | input | 1 | Card signals busy |
| ack_in | input | 1 | Card acknowledgment seen |
| err_in | input | 1 | Transfer error, aborts |
| state | output | 3 | Sequencer state code |
| remain | output | LEN_W | Remaining byte count |
| data_end | output | 1 | Transfer completed pulse |
| data_tmo | output | 1 | Data timeout pulse |
| ack_tmo | output | 1 | Acknowledgment timeout pulse |

## Verification
Transfers run in both directions, with and without the acknowledgment wait. The lengths used are multiples of four, non-multiples and zero. Non-multiples show the saturating decrement, and zero shows the immediate hand-off from the transfer state. Timeout cases hold off the card response until the final pulse, and the state is checked one pulse earlier, which separates an off-by-one timer from a correct one. Completion is also made to fall on the expiry pulse, which checks the priority rule. Directed cases cover a stray start, errors both inside and outside Idle, a zero timeout value and reset in mid-transfer.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_WAIT_S = 3'd1,
    S_SEND   = 3'd2,
    S_BUSY   = 3'd3,
    S_WAIT_R = 3'd4,
    S_RECV   = 3'd5,
    S_WAIT_A = 3'd6
  } dps_state_e;
endpackage

// File: rtl/dps_lencnt.sv
module dps_lencnt #(
  parameter int LEN_W = 16,
  parameter int BPW   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic [LEN_W-1:0] cnt
);
  localparam logic [LEN_W-1:0] STEP = LEN_W'(BPW);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec) begin
      cnt <= (cnt < STEP) ? '0 : cnt - STEP;
    end
  end
endmodule

// File: rtl/dps_wdog.sv
module dps_wdog #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  input  logic             ck_en,
  input  logic [TMR_W-1:0] reload,
  output logic             expire
);
  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);
  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!armed) begin
      cnt <= reload;
    end else if (ck_en && cnt != '0) begin
      cnt <= cnt - ONE;
    end
  end

  assign expire = armed && ck_en && (cnt <= ONE);
endmodule

// File: rtl/dps_ctrl.sv
module dps_ctrl
  import dps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       dir_rx,
  input  logic       ack_req,
  input  logic       ck_en,
  input  logic       word_stb,
  input  logic       rx_begin,
  input  logic       card_busy,
  input  logic       ack_in,
  input  logic       err_in,
  input  logic       len_zero,
  input  logic       dt_exp,
  input  logic       at_exp,
  output dps_state_e st,
  output logic       load_len,
  output logic       dec_len,
  output logic       dt_arm,
  output logic       at_arm,
  output logic       de_q,
  output logic       dto_q,
  output logic       ato_q
);
  dps_state_e nxt;
  logic de_n, dto_n, ato_n;

  assign load_len = (st == S_IDLE) && start;
  assign dec_len  = ((st == S_SEND) || (st == S_RECV)) && word_stb;
  assign dt_arm   = (st == S_WAIT_R) || (st == S_BUSY);
  assign at_arm   = (st == S_WAIT_A);

  always_comb begin
    nxt   = st;
    de_n  = 1'b0;
    dto_n = 1'b0;
    ato_n = 1'b0;
    if (st != S_IDLE && err_in) begin
      nxt = S_IDLE;
    end else begin
      case (st)
        S_IDLE:   if (start) nxt = dir_rx ? S_WAIT_R : S_WAIT_S;
        S_WAIT_S: if (ck_en) nxt = S_SEND;
        S_SEND:   if (len_zero) nxt = S_BUSY;
        S_BUSY: begin
          if (ck_en && !card_busy) begin
            nxt = S_IDLE; de_n = 1'b1;
          end else if (dt_exp) begin
            nxt = S_IDLE; dto_n = 1'b1;
          end
        end
        S_WAIT_R: begin
          if (ck_en && rx_begin) begin
            nxt = S_RECV;
          end else if (dt_exp) begin
            nxt = S_IDLE; dto_n = 1'b1;
          end
        end
        S_RECV: begin
          if (len_zero) begin
            if (ack_req) begin
              nxt = S_WAIT_A;
            end else begin
              nxt = S_IDLE; de_n = 1'b1;
            end
          end
        end
        S_WAIT_A: begin
          if (ck_en && ack_in) begin
            nxt = S_IDLE; de_n = 1'b1;
          end else if (at_exp) begin
            nxt = S_IDLE; ato_n = 1'b1;
          end
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      de_q  <= 1'b0;
      dto_q <= 1'b0;
      ato_q <= 1'b0;
    end else begin
      st    <= nxt;
      de_q  <= de_n;
      dto_q <= dto_n;
      ato_q <= ato_n;
    end
  end
endmodule

// File: rtl/card_dpath_seq.sv
module card_dpath_seq
  import dps_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int TMR_W = 16,
  parameter int BPW   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ck_en,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [TMR_W-1:0] cfg_dtime,
  input  logic [TMR_W-1:0] cfg_atime,
  input  logic             start,
  input  logic             dir_rx,
  input  logic             ack_req,
  input  logic             word_stb,
  input  logic             rx_begin,
  input  logic             card_busy,
  input  logic             ack_in,
  input  logic             err_in,
  output logic [2:0]       state,
  output logic [LEN_W-1:0] remain,
  output logic             data_end,
  output logic             data_tmo,
  output logic             ack_tmo
);
  dps_state_e st;
  logic load_len, dec_len, dt_arm, at_arm, dt_exp, at_exp;

  dps_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .dir_rx(dir_rx), .ack_req(ack_req),
    .ck_en(ck_en), .word_stb(word_stb), .rx_begin(rx_begin),
    .card_busy(card_busy), .ack_in(ack_in), .err_in(err_in),
    .len_zero(remain == '0), .dt_exp(dt_exp), .at_exp(at_exp),
    .st(st), .load_len(load_len), .dec_len(dec_len),
    .dt_arm(dt_arm), .at_arm(at_arm),
    .de_q(data_end), .dto_q(data_tmo), .ato_q(ack_tmo)
  );

  dps_lencnt #(.LEN_W(LEN_W), .BPW(BPW)) u_len (
    .clk(clk), .rst(rst), .load(load_len), .load_val(cfg_len),
    .dec(dec_len), .cnt(remain)
  );

  dps_wdog #(.TMR_W(TMR_W)) u_dtmr (
    .clk(clk), .rst(rst), .armed(dt_arm), .ck_en(ck_en),
    .reload(cfg_dtime), .expire(dt_exp)
  );

  dps_wdog #(.TMR_W(TMR_W)) u_atmr (
    .clk(clk), .rst(rst), .armed(at_arm), .ck_en(ck_en),
    .reload(cfg_atime), .expire(at_exp)
  );

  assign state = st;
endmodule

// File: rtl/dps_chk.sv
module dps_chk #(
  parameter int LEN_W = 16,
  parameter int TMR_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ck_en,
  input logic [LEN_W-1:0] cfg_len,
  input logic             start,
  input logic             dir_rx,
  input logic             err_in,
  input logic [2:0]       state,
  input logic [LEN_W-1:0] remain,
  input logic             data_end,
  input logic             data_tmo,
  input logic             ack_tmo
);
  // R11
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({data_end, data_tmo, ack_tmo}));

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd0 && start) |=> (remain == $past(cfg_len)) &&
      (state == ($past(dir_rx) ? 3'd4 : 3'd1)));

  // R3
  no_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (state != 3'd0) |=> (remain <= $past(remain)));

  // R4
  wait_send_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd1 && !ck_en && !err_in) |=> (state == 3'd1));

  // R6
  end_origin_chk: assert property (@(posedge clk) disable iff (rst)
    data_end |-> (state == 3'd0) &&
      ($past(state) == 3'd3 || $past(state) == 3'd5 || $past(state) == 3'd6));

  // R7
  dtmo_origin_chk: assert property (@(posedge clk) disable iff (rst)
    data_tmo |-> (state == 3'd0) && ($past(state) == 3'd4 || $past(state) == 3'd3));

  // R8
  atmo_origin_chk: assert property (@(posedge clk) disable iff (rst)
    ack_tmo |-> (state == 3'd0) && ($past(state) == 3'd6));

  // R10
  err_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state != 3'd0 && err_in) |=> (state == 3'd0) && !data_end && !data_tmo && !ack_tmo);
endmodule

bind card_dpath_seq dps_chk #(.LEN_W(LEN_W), .TMR_W(TMR_W)) u_chk (.*);

// File: tb/sim_card_dpath_seq.sv
module sim_card_dpath_seq;
  localparam int LW = 16;
  localparam int TW = 16;
  localparam int DT = 3;
  localparam int AT = 2;
  localparam int NV = 10;
  // entry: {rx, ack, mode[1:0], len[11:0]}; mode 0 complete, 1 data timeout, 2 ack timeout
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'd0, 12'd16}, {1'b0, 1'b0, 2'd0, 12'd8},
    {1'b1, 1'b1, 2'd0, 12'd12}, {1'b1, 1'b0, 2'd0, 12'd0},
    {1'b1, 1'b0, 2'd0, 12'd6},  {1'b0, 1'b0, 2'd0, 12'd5},
    {1'b1, 1'b0, 2'd1, 12'd8},  {1'b0, 1'b0, 2'd1, 12'd4},
    {1'b1, 1'b1, 2'd2, 12'd4},  {1'b0, 1'b0, 2'd0, 12'd0}
  };

  logic clk = 1'b0, rst = 1'b1, ck_en = 1'b0;
  logic [LW-1:0] cfg_len = '0;
  logic [TW-1:0] cfg_dtime = TW'(DT), cfg_atime = TW'(AT);
  logic start = 0, dir_rx = 0, ack_req = 0, word_stb = 0;
  logic rx_begin = 0, card_busy = 0, ack_in = 0, err_in = 0;
  logic [2:0] state;
  logic [LW-1:0] remain;
  logic data_end, data_tmo, ack_tmo;
  int n_tot = 0, n_bad = 0;

  always #4 clk = ~clk;

  card_dpath_seq u0 (.*);

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tot++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic flags(input string req, input int de, input int dto, input int ato);
    chk(req, "data_end", int'(data_end), de);
    chk(req, "data_tmo", int'(data_tmo), dto);
    chk(req, "ack_tmo", int'(ack_tmo), ato);
  endtask

  task automatic pulse();
    ck_en = 1; step(); ck_en = 0;
  endtask

  task automatic wait_pulses(input int n);
    for (int k = 0; k < n; k++) begin pulse(); step(); end
  endtask

  task automatic run_vec(input logic rx, input logic ack, input int mode, input int len);
    int exp_cnt;
    cfg_len = LW'(len); dir_rx = rx; ack_req = ack; start = 1; step(); start = 0;
    chk("R2", "state", int'(state), rx ? 4 : 1);
    chk("R2", "remain", int'(remain), len);
    exp_cnt = len;
    if (rx) begin
      if (mode == 1) begin
        wait_pulses(DT - 1);
        chk("R7", "state", int'(state), 4);
        pulse();
        chk("R7", "state", int'(state), 0);
        flags("R7", 0, 1, 0);
        step(); flags("R11", 0, 0, 0);
        return;
      end
      ck_en = 1; rx_begin = 1; step(); ck_en = 0; rx_begin = 0;
      chk("R4", "state", int'(state), 5);
    end else begin
      pulse();
      chk("R4", "state", int'(state), 2);
    end
    for (int w = 0; w < (len + 3) / 4; w++) begin
      word_stb = 1; step(); word_stb = 0;
      exp_cnt = (exp_cnt < 4) ? 0 : exp_cnt - 4;
      chk("R3", "remain", int'(remain), exp_cnt);
    end
    chk("R5", "state", int'(state), rx ? 5 : 2);
    step();
    if (rx && !ack) begin
      chk("R5", "state", int'(state), 0);
      flags("R5", 1, 0, 0);
    end else if (rx) begin
      chk("R5", "state", int'(state), 6);
      wait_pulses(AT - 1);
      chk("R8", "state", int'(state), 6);
      ack_in = (mode != 2); pulse(); ack_in = 0;
      chk("R9", "state", int'(state), 0);
      if (mode == 2) flags("R8", 0, 0, 1); else flags("R9", 1, 0, 0);
    end else begin
      chk("R5", "state", int'(state), 3);
      card_busy = 1;
      wait_pulses(DT - 1);
      chk("R7", "state", int'(state), 3);
      card_busy = (mode == 1); pulse(); card_busy = 0;
      chk("R6", "state", int'(state), 0);
      if (mode == 1) flags("R7", 0, 1, 0); else flags("R9", 1, 0, 0);
    end
    step(); flags("R11", 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); step(); step();
    rst = 0; step();
    chk("R1", "state", int'(state), 0);
    chk("R1", "remain", int'(remain), 0);
    flags("R1", 0, 0, 0);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][15], VEC[v][14], int'(VEC[v][13:12]), int'(VEC[v][11:0]));

    // R10: error in Idle has no effect
    err_in = 1; step(); err_in = 0;
    chk("R10", "state", int'(state), 0);
    flags("R10", 0, 0, 0);

    // R3: start during Recv ignored, then R10 abort
    cfg_len = 16; dir_rx = 1; ack_req = 0; start = 1; step(); start = 0;
    ck_en = 1; rx_begin = 1; step(); ck_en = 0; rx_begin = 0;
    word_stb = 1; step(); word_stb = 0;
    chk("R3", "remain", int'(remain), 12);
    cfg_len = 100; dir_rx = 0; start = 1; step(); start = 0;
    chk("R3", "state", int'(state), 5);
    chk("R3", "remain", int'(remain), 12);
    err_in = 1; step(); err_in = 0;
    chk("R10", "state", int'(state), 0);
    flags("R10", 0, 0, 0);
    step(); flags("R10", 0, 0, 0);

    // R10: error during Send
    cfg_len = 8; dir_rx = 0; start = 1; step(); start = 0;
    pulse();
    chk("R4", "state", int'(state), 2);
    err_in = 1; step(); err_in = 0;
    chk("R10", "state", int'(state), 0);
    flags("R10", 0, 0, 0);

    // R7: zero timeout value acts as one pulse
    cfg_dtime = '0; cfg_len = 4; dir_rx = 1; start = 1; step(); start = 0;
    step();
    chk("R7", "state", int'(state), 4);
    pulse();
    chk("R7", "state", int'(state), 0);
    flags("R7", 0, 1, 0);
    cfg_dtime = TW'(DT);

    // R7: timer reloads on each entry (partial wait, then full wait again)
    cfg_len = 0; dir_rx = 1; start = 1; step(); start = 0;
    wait_pulses(DT - 1);
    ck_en = 1; rx_begin = 1; step(); ck_en = 0; rx_begin = 0;
    step();
    chk("R5", "state", int'(state), 0);
    start = 1; step(); start = 0;
    wait_pulses(DT - 1);
    chk("R7", "state", int'(state), 4);
    pulse();
    flags("R7", 0, 1, 0);

    // R1: reset in mid-transfer
    cfg_len = 20; dir_rx = 0; start = 1; step(); start = 0;
    pulse();
    rst = 1; step(); rst = 0;
    chk("R1", "state", int'(state), 0);
    chk("R1", "remain", int'(remain), 0);
    flags("R1", 0, 0, 0);

    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule